// File: doc/BRIEF.md
# Triggered Delayed One-Shot Pulse Timer

This block is a 16-bit up-counter that generates one delayed output pulse each time it is fired. A selectable edge on an asynchronous trigger pin, or a software fire bit in the control word, clears the counter to zero and sets it running on a prescaled count tick. Two compare registers shape the pulse. Whenever the counter steps onto the value in compare register 1, the output flip-flop inverts, provided that inversion is enabled. Whenever the counter steps onto compare register 0, the flip-flop inverts unconditionally. Compare 1 therefore places the leading edge, compare 0 places the trailing edge, and the pulse lasts (compare 0 − compare 1) count ticks.

Software sets the block up through a plain write/read port with four word addresses: control, compare 0, compare 1 and the live count. From the control word it chooses the trigger edge, the count-tick divider, the output enable and the compare 1 enable. A write to the control word can also force the flip-flop to a chosen level, fire the timer and clear the wrap flag. When the output enable is off, the pin is held at the inactive level 0. A fire that arrives while a pulse is running restarts the count from zero and leaves the flip-flop level as it was.

Top module: `oneshot_pulse_timer`

## Requirements
- R1: After reset the count reads 0, the control word reads 0, both compare registers read 16'hFFFF and pulse_out is 0.
- R2: A control write (address 0) with bit 1 set and bit 0 (run enable) set clears the count to 0 at that clock edge and starts it counting. Bit 1 always reads back 0.
- R3: Control bits [3:2] select the trigger edge: 00 rising, 01 falling, 10 both, 11 invalid (never fires). The pin passes through a two-flop synchronizer, so a valid edge has cleared the count by the third rising clock edge after the pin changes. While bit 0 is 0 the count is held at 0 and triggers are ignored.
- R4: Control bits [5:4] select the count tick: 00 every clock, 01 every 4 clocks, 10 every 16 clocks, 11 no tick (count frozen). The divider restarts on each fire, so the first increment comes N clocks after the fire.
- R5: The output flip-flop inverts on the clock edge at which the running count steps onto the value of compare register 0 (address 1).
- R6: When control bit 9 is 1, the flip-flop also inverts when the count steps onto compare register 1 (address 2). With compare 1 < compare 0, pulse_out is high for exactly (compare 0 − compare 1) clocks at the undivided tick. When bit 9 is 0, compare 1 has no effect.
- R7: A write of zero to either compare register is rejected, and the register keeps its previous value.
- R8: Control bits [8:7] load the flip-flop on a control write: 01 loads 0, 10 loads 1, 00 and 11 leave it unchanged. These bits read back as 0.
- R9: Control bit 6 is the output enable. When it is 0, pulse_out is 0 whatever the flip-flop holds.
- R10: When the running count wraps from 16'hFFFF to 0, control bit 10 sets and stays set. A control write with bit 10 set clears it.
- R11: A fire during a pulse restarts the count from 0 and leaves the flip-flop level unchanged.
- R12: When two events fall in the same cycle, the following rules apply. A fire takes priority over a compare match, and that match does not invert the flip-flop. Equal compare values with bit 9 set invert the flip-flop twice, so its level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 control, 1 compare 0, 2 compare 1, 3 count |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| trig_in | input | 1 | Asynchronous trigger pin |
| pulse_out | output | 1 | Gated output flip-flop |

## Verification
Two functions can land on the same clock edge: a fire, which clears the count, and a compare match, which inverts the flip-flop. The bench provokes this by issuing a software fire exactly on the edge where the count would step onto compare 0. It then checks that the count reads 0 and pulse_out is still low, and that the inversion occurs a full period later. The other coincidence, both compare matches on one edge, is set up with equal compare values and compare 1 enabled. It is judged by pulse_out staying low across the whole observation window.

// File: rtl/otp_pkg.sv
package otp_pkg;
   // control word bit positions
   localparam int B_MODE    = 0;
   localparam int B_TRIG    = 1;
   localparam int B_EDGE    = 2;
   localparam int B_PRE     = 4;
   localparam int B_OE      = 6;
   localparam int B_INIT    = 7;
   localparam int B_EN1     = 9;
   localparam int B_OVF     = 10;
   localparam int CTRL_BITS = 11;

   // word addresses
   localparam logic [1:0] ADDR_CTRL  = 2'd0;
   localparam logic [1:0] ADDR_CMP0  = 2'd1;
   localparam logic [1:0] ADDR_CMP1  = 2'd2;
   localparam logic [1:0] ADDR_COUNT = 2'd3;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_BOTH = 2'b10,
      EDGE_NONE = 2'b11
   } edge_sel_e;

   typedef enum logic [1:0] {
      TICK_DIV1  = 2'b00,
      TICK_DIVA  = 2'b01,
      TICK_DIVB  = 2'b10,
      TICK_OFF   = 2'b11
   } tick_sel_e;
endpackage

// File: rtl/otp_sync_edge.sv
module otp_sync_edge import otp_pkg::*; #(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      trig_async,
   input  edge_sel_e edge_sel,
   output logic      fire
);
   if (STAGES < 2) begin : g_bad_stages
      $error("otp_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;
   logic              rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], trig_async};
         prev  <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~prev;
   assign fall = ~chain[STAGES-1] & prev;

   always_comb begin
      unique case (edge_sel)
         EDGE_RISE: fire = rise;
         EDGE_FALL: fire = fall;
         EDGE_BOTH: fire = rise | fall;
         default:   fire = 1'b0;
      endcase
   end
endmodule

// File: rtl/otp_prescale.sv
module otp_prescale import otp_pkg::*; #(
   parameter int SHIFT_A = 2,
   parameter int SHIFT_B = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      restart,
   input  tick_sel_e sel,
   output logic      tick
);
   if (SHIFT_A < 1 || SHIFT_B <= SHIFT_A) begin : g_bad_shift
      $error("otp_prescale: need 1 <= SHIFT_A < SHIFT_B");
   end

   logic [SHIFT_B-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       div_q <= '0;
      else if (restart) div_q <= '0;
      else              div_q <= div_q + 1'b1;
   end

   always_comb begin
      unique case (sel)
         TICK_DIV1: tick = 1'b1;
         TICK_DIVA: tick = &div_q[SHIFT_A-1:0];
         TICK_DIVB: tick = &div_q;
         default:   tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/otp_core.sv
module otp_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         mode,
   input  logic         start,
   input  logic         tick,
   input  logic [W-1:0] cmp0,
   input  logic [W-1:0] cmp1,
   input  logic         en1,
   input  logic         init_load,
   input  logic         init_val,
   output logic [W-1:0] count,
   output logic         running,
   output logic         flop,
   output logic         wrap
);
   logic         step;
   logic [W-1:0] next;
   logic         hit0, hit1;

   assign step = mode && running && tick && !start;
   assign next = count + 1'b1;
   assign hit0 = step && (next == cmp0);
   assign hit1 = step && en1 && (next == cmp1);
   assign wrap = step && (count == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         running <= 1'b0;
      end else if (!mode) begin
         count   <= '0;
         running <= 1'b0;
      end else if (start) begin
         count   <= '0;
         running <= 1'b1;
      end else if (step) begin
         count   <= next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flop <= 1'b0;
      else if (init_load)    flop <= init_val;
      else if (hit0 ^ hit1)  flop <= ~flop;
   end
endmodule

// File: rtl/oneshot_pulse_timer.sv
module oneshot_pulse_timer import otp_pkg::*; #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int PRE_SHIFT_A = 2,
   parameter int PRE_SHIFT_B = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [1:0]       reg_addr,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   input  logic             trig_in,
   output logic             pulse_out
);
   if (CNT_W <= CTRL_BITS) begin : g_bad_width
      $error("oneshot_pulse_timer: CNT_W must exceed the control word width");
   end

   logic             mode_q, oe_q, en1_q, ovf_q;
   edge_sel_e        edge_q;
   tick_sel_e        pre_q;
   logic [CNT_W-1:0] cmp0_q, cmp1_q, count_q;
   logic             ctrl_wr, mode_now, ext_fire, start, tick;
   logic             running, wrap, flop, init_load;
   logic             wdata_unused;

   assign wdata_unused = ^reg_wdata[CNT_W-1:CTRL_BITS];
   assign ctrl_wr   = reg_we && (reg_addr == ADDR_CTRL);
   assign mode_now  = ctrl_wr ? reg_wdata[B_MODE] : mode_q;
   assign start     = mode_now && (ext_fire || (ctrl_wr && reg_wdata[B_TRIG]));
   assign init_load = ctrl_wr && (reg_wdata[B_INIT+1] ^ reg_wdata[B_INIT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         oe_q   <= 1'b0;
         en1_q  <= 1'b0;
         edge_q <= EDGE_RISE;
         pre_q  <= TICK_DIV1;
         cmp0_q <= '1;
         cmp1_q <= '1;
      end else if (reg_we) begin
         unique case (reg_addr)
            ADDR_CTRL: begin
               mode_q <= reg_wdata[B_MODE];
               oe_q   <= reg_wdata[B_OE];
               en1_q  <= reg_wdata[B_EN1];
               edge_q <= edge_sel_e'(reg_wdata[B_EDGE +: 2]);
               pre_q  <= tick_sel_e'(reg_wdata[B_PRE +: 2]);
            end
            ADDR_CMP0: if (reg_wdata != '0) cmp0_q <= reg_wdata;
            ADDR_CMP1: if (reg_wdata != '0) cmp1_q <= reg_wdata;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ovf_q <= 1'b0;
      else if (wrap)                       ovf_q <= 1'b1;
      else if (ctrl_wr && reg_wdata[B_OVF]) ovf_q <= 1'b0;
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADDR_CTRL: begin
            reg_rdata[B_MODE]       = mode_q;
            reg_rdata[B_EDGE +: 2]  = edge_q;
            reg_rdata[B_PRE +: 2]   = pre_q;
            reg_rdata[B_OE]         = oe_q;
            reg_rdata[B_EN1]        = en1_q;
            reg_rdata[B_OVF]        = ovf_q;
         end
         ADDR_CMP0:  reg_rdata = cmp0_q;
         ADDR_CMP1:  reg_rdata = cmp1_q;
         default:    reg_rdata = count_q;
      endcase
   end

   otp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .trig_async(trig_in), .edge_sel(edge_q), .fire(ext_fire)
   );

   otp_prescale #(.SHIFT_A(PRE_SHIFT_A), .SHIFT_B(PRE_SHIFT_B)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(start), .sel(pre_q), .tick(tick)
   );

   otp_core #(.W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .mode(mode_now), .start(start), .tick(tick),
      .cmp0(cmp0_q), .cmp1(cmp1_q), .en1(en1_q),
      .init_load(init_load), .init_val(reg_wdata[B_INIT+1]),
      .count(count_q), .running(running), .flop(flop), .wrap(wrap)
   );

   assign pulse_out = oe_q & flop;
endmodule

// File: rtl/otp_checker.sv
module otp_checker #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         mode,
   input logic         start,
   input logic         running,
   input logic [W-1:0] count,
   input logic         ovf,
   input logic         wrap,
   input logic [W-1:0] cmp0,
   input logic [W-1:0] cmp1,
   input logic [1:0]   pre_sel
);
   AST_CMP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) (cmp0 != '0) && (cmp1 != '0)); // R7
   AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (mode && start) |=> (count == '0) && running); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !mode |=> (count == '0) && !running); // R3
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (mode && !start && pre_sel == 2'b11) |=> $stable(count)); // R4
   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n) (mode && !start) |=> (count == $past(count)) || (count == W'($past(count) + 1'b1))); // R4
   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> ovf); // R10
endmodule

bind oneshot_pulse_timer otp_checker #(.W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode_now), .start(start), .running(running),
   .count(count_q), .ovf(ovf_q), .wrap(wrap), .cmp0(cmp0_q), .cmp1(cmp1_q), .pre_sel(pre_q)
);

// File: tb/sim_oneshot_pulse_timer.sv
module sim_oneshot_pulse_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        trig_in = 1'b0;
   logic        pulse_out;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   oneshot_pulse_timer u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in), .pulse_out(pulse_out)
   );

   // control word: run[0] fire[1] edge[3:2] tick[5:4] oe[6] level[8:7] en1[9] wrapclr[10]
   function automatic logic [15:0] cw(input bit run, input bit fire, input logic [1:0] edg,
                                      input logic [1:0] pre, input bit oe, input logic [1:0] lvl,
                                      input bit en1, input bit oclr);
      logic [15:0] v;
      v = '0;
      v[0] = run; v[1] = fire; v[3:2] = edg; v[5:4] = pre;
      v[6] = oe; v[8:7] = lvl; v[9] = en1; v[10] = oclr;
      return v;
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   // cmp1, cmp0, en1, expected first-high clock, expected high clocks (window cmp0+4)
   localparam logic [15:0] VEC [6][5] = '{
      '{16'd3,  16'd10, 16'd1, 16'd3,  16'd7},
      '{16'd1,  16'd2,  16'd1, 16'd1,  16'd1},
      '{16'd5,  16'd9,  16'd0, 16'd9,  16'd5},
      '{16'd6,  16'd6,  16'd1, 16'd0,  16'd0},
      '{16'd6,  16'd4,  16'd1, 16'd4,  16'd2},
      '{16'd20, 16'd40, 16'd1, 16'd20, 16'd20}
   };

   task automatic edge_case(input string req, input logic [1:0] edg, input bit run,
                            input logic start_lvl, input logic exp_fire);
      logic [15:0] d;
      trig_in = start_lvl;
      repeat (4) @(posedge clk); #1;
      wr(2'd0, cw(0, 0, 2'b11, 2'b00, 0, 2'b00, 0, 0));
      wr(2'd0, cw(run, 0, edg, 2'b00, 0, 2'b00, 0, 0));
      trig_in = ~start_lvl;
      repeat (8) @(posedge clk); #1;
      rd(2'd3, d);
      check(req, d, exp_fire ? 16'd5 : 16'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(posedge clk); #1;
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      rd(2'd3, d); check("R1 count", d, 16'd0);
      rd(2'd0, d); check("R1 ctrl", d, 16'd0);
      rd(2'd1, d); check("R1 cmp0", d, 16'hFFFF);
      rd(2'd2, d); check("R1 cmp1", d, 16'hFFFF);
      check("R1 pulse_out", {15'd0, pulse_out}, 16'd0);

      // R5 R6 R12 pulse shapes from the vector table
      foreach (VEC[v]) begin
         int first_hi;
         int highs;
         int win;
         first_hi = 0; highs = 0;
         win = int'(VEC[v][1]) + 4;
         wr(2'd1, VEC[v][1]);
         wr(2'd2, VEC[v][0]);
         wr(2'd0, cw(1, 1, 2'b11, 2'b00, 1, 2'b01, VEC[v][2][0], 0));
         for (int i = 1; i <= win; i++) begin
            @(posedge clk); #1;
            if (pulse_out) begin
               highs++;
               if (first_hi == 0) first_hi = i;
            end
         end
         check($sformatf("R5/R6/R12 vector %0d first high", v), 16'(first_hi), VEC[v][3]);
         check($sformatf("R5/R6/R12 vector %0d high clocks", v), 16'(highs), VEC[v][4]);
      end

      // R2 software fire reads back zero and clears count
      rd(2'd0, d); check("R2 fire bit reads 0", {15'd0, d[1]}, 16'd0);
      wr(2'd0, cw(1, 1, 2'b11, 2'b00, 1, 2'b01, 0, 0));
      rd(2'd3, d); check("R2 count cleared", d, 16'd0);
      repeat (6) @(posedge clk); #1;
      rd(2'd3, d); check("R2 count runs", d, 16'd6);

      // R3 trigger edge codes, latency and run gating
      edge_case("R3 rising code, rising pin",  2'b00, 1, 1'b0, 1'b1);
      edge_case("R3 rising code, falling pin", 2'b00, 1, 1'b1, 1'b0);
      edge_case("R3 falling code, falling pin", 2'b01, 1, 1'b1, 1'b1);
      edge_case("R3 both code, rising pin",    2'b10, 1, 1'b0, 1'b1);
      edge_case("R3 invalid code",             2'b11, 1, 1'b0, 1'b0);
      edge_case("R3 run off ignores trigger",  2'b00, 0, 1'b0, 1'b0);
      trig_in = 1'b0;

      // R4 tick divider
      wr(2'd0, cw(1, 1, 2'b11, 2'b01, 0, 2'b00, 0, 0));
      repeat (3) @(posedge clk); #1; rd(2'd3, d); check("R4 div4 before", d, 16'd0);
      @(posedge clk); #1; rd(2'd3, d); check("R4 div4 first", d, 16'd1);
      repeat (4) @(posedge clk); #1; rd(2'd3, d); check("R4 div4 second", d, 16'd2);
      wr(2'd0, cw(1, 1, 2'b11, 2'b10, 0, 2'b00, 0, 0));
      repeat (15) @(posedge clk); #1; rd(2'd3, d); check("R4 div16 before", d, 16'd0);
      @(posedge clk); #1; rd(2'd3, d); check("R4 div16 first", d, 16'd1);
      wr(2'd0, cw(1, 1, 2'b11, 2'b11, 0, 2'b00, 0, 0));
      repeat (10) @(posedge clk); #1; rd(2'd3, d); check("R4 tick off frozen", d, 16'd0);

      // R7 zero writes rejected
      wr(2'd1, 16'd77); wr(2'd1, 16'd0); rd(2'd1, d); check("R7 cmp0 keeps", d, 16'd77);
      wr(2'd2, 16'd33); wr(2'd2, 16'd0); rd(2'd2, d); check("R7 cmp1 keeps", d, 16'd33);

      // R8 R9 level load and output enable (run off, no toggles)
      wr(2'd0, cw(0, 0, 2'b11, 2'b00, 1, 2'b10, 0, 0));
      check("R8 load 1", {15'd0, pulse_out}, 16'd1);
      wr(2'd0, cw(0, 0, 2'b11, 2'b00, 1, 2'b11, 0, 0));
      check("R8 code 11 no change", {15'd0, pulse_out}, 16'd1);
      rd(2'd0, d); check("R8 level bits read 0", {14'd0, d[8:7]}, 16'd0);
      wr(2'd0, cw(0, 0, 2'b11, 2'b00, 0, 2'b00, 0, 0));
      check("R9 disabled drives 0", {15'd0, pulse_out}, 16'd0);
      wr(2'd0, cw(0, 0, 2'b11, 2'b00, 1, 2'b00, 0, 0));
      check("R9 re-enabled shows 1", {15'd0, pulse_out}, 16'd1);
      wr(2'd0, cw(0, 0, 2'b11, 2'b00, 1, 2'b01, 0, 0));
      check("R8 load 0", {15'd0, pulse_out}, 16'd0);

      // R11 retrigger mid pulse
      wr(2'd1, 16'd30); wr(2'd2, 16'd3);
      wr(2'd0, cw(1, 1, 2'b11, 2'b00, 1, 2'b01, 1, 0));
      repeat (10) @(posedge clk); #1;
      check("R11 high mid pulse", {15'd0, pulse_out}, 16'd1);
      wr(2'd0, cw(1, 1, 2'b11, 2'b00, 1, 2'b00, 1, 0));
      rd(2'd3, d); check("R11 count restarted", d, 16'd0);
      check("R11 level kept", {15'd0, pulse_out}, 16'd1);

      // R12 fire on the same edge as a compare 0 match
      wr(2'd1, 16'd10);
      wr(2'd0, cw(1, 1, 2'b11, 2'b00, 1, 2'b01, 0, 0));
      repeat (9) @(posedge clk); #1;
      wr(2'd0, cw(1, 1, 2'b11, 2'b00, 1, 2'b00, 0, 0));
      rd(2'd3, d); check("R12 fire wins count", d, 16'd0);
      check("R12 no inversion on collision", {15'd0, pulse_out}, 16'd0);
      repeat (10) @(posedge clk); #1;
      check("R12 inversion one period later", {15'd0, pulse_out}, 16'd1);

      // R10 wrap flag
      wr(2'd0, cw(1, 1, 2'b11, 2'b00, 0, 2'b00, 0, 0));
      repeat (65535) @(posedge clk); #1;
      rd(2'd3, d); check("R10 count at max", d, 16'hFFFF);
      rd(2'd0, d); check("R10 flag clear before wrap", {15'd0, d[10]}, 16'd0);
      @(posedge clk); #1;
      rd(2'd3, d); check("R10 count wrapped", d, 16'd0);
      rd(2'd0, d); check("R10 flag set", {15'd0, d[10]}, 16'd1);
      repeat (5) @(posedge clk); #1;
      rd(2'd0, d); check("R10 flag sticky", {15'd0, d[10]}, 16'd1);
      wr(2'd0, cw(0, 0, 2'b11, 2'b00, 0, 2'b00, 0, 1));
      rd(2'd0, d); check("R10 flag cleared", {15'd0, d[10]}, 16'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule